// File: doc/BRIEF.md
# Watchdog and Supply Reset Controller

This block produces one stretched system reset from two causes. The first is a watchdog that watches a serial-bus chip-select line. Only a high-to-low transition of that line, seen after synchronization, restarts the watchdog. If the line stays at either level for longer than the selected period, the watchdog times out. The second cause is a digital supply-good indication. While that indication is low, reset is held. Reset is let go only after supply-good has stayed high for a fixed release interval.

All timing counts pulses of a free-running tick input, nominally one per millisecond, so every period is expressed as a tick count. A 2-bit select picks one of three watchdog periods, and the fourth code turns the watchdog off. A parameter sets the output polarity. After the asynchronous reset, the block holds reset for a separate power-up interval. Nothing is stored across power cycles: the select bits come from outside.

Top module: `wdt_supply_reset`

## Requirements
- R1: The select input picks the watchdog period: 00 = LONG_TICKS, 01 = MID_TICKS, 10 = SHORT_TICKS.
- R2: A falling edge of cs_i, taken after a two-flop synchronizer, clears the watchdog count. The count is cleared three clock edges after the change at the pin.
- R3: If cs_i shows no falling edge, the watchdog expires on the tick that completes the selected period. This holds whether cs_i stays high or low, and a rising edge does not restart the count.
- R4: On watchdog expiry, reset asserts on the next clock edge and stays asserted for exactly RST_TICKS ticks.
- R5: While supply_ok_i is low, reset is asserted from the next clock edge. Reset releases on the RST_TICKS-th tick after supply_ok_i returns high.
- R6: After rst_ni is released, reset stays asserted for PUR_TICKS ticks.
- R7: With ACTIVE_HIGH = 1, reset_o is high while reset is asserted. With ACTIVE_HIGH = 0, reset_o is low while reset is asserted.
- R8: If supply_ok_i falls during a watchdog reset pulse, the pulse is extended. The RST_TICKS release interval then restarts from the moment supply_ok_i returns high.
- R9: While reset is asserted, the watchdog count is held at zero. After release, a full period is needed for the next expiry.
- R10: A change of the select value clears the watchdog count, so the new period runs from the change.
- R11: Select value 11 disables the watchdog: no expiry occurs, however many ticks pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-up) |
| tick_i | input | 1 | One-cycle time-base pulse |
| sel_i | input | 2 | Watchdog period select |
| cs_i | input | 1 | Asynchronous chip-select line that is watched |
| supply_ok_i | input | 1 | Synchronous supply-good indication |
| reset_o | output | 1 | Stretched reset, polarity set by ACTIVE_HIGH |

## Verification
The bench builds two copies of the block, one for each polarity. Both use tick counts of 9, 6 and 3 for the watchdog periods, 4 for the reset stretch and 5 for power-up. With counts this small, the bench can sweep the kick position across every tick of every period. It can also probe the cycle just before and just after each expiry and each release. Every check compares both outputs, which covers the polarity requirement throughout. The short periods also make it possible to tell a restarted release interval apart from an interrupted one.

// File: rtl/wsr_pkg.sv
package wsr_pkg;

  typedef enum logic [1:0] {
    WD_LONG  = 2'b00,
    WD_MID   = 2'b01,
    WD_SHORT = 2'b10,
    WD_OFF   = 2'b11
  } wd_sel_e;

endpackage

// File: rtl/wsr_cs_sync.sv
module wsr_cs_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  output logic cs_fall_o
);

  // [0..SYNC_STAGES-1] synchronizer, [SYNC_STAGES] edge-detect delay
  logic [SYNC_STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[SYNC_STAGES-1:0], cs_i};
  end

  assign cs_fall_o = pipe_q[SYNC_STAGES] & ~pipe_q[SYNC_STAGES-1];

  p_single_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall_o |=> !cs_fall_o);

endmodule

// File: rtl/wsr_wdog.sv
module wsr_wdog #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             enable_i,
  input  logic             hold_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  assign at_end   = (cnt_q == period_i - CNT_W'(1));
  assign expire_o = tick_i & enable_i & ~hold_i & ~restart_i & at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cnt_q <= '0;
    else if (hold_i || !enable_i || restart_i) cnt_q <= '0;
    else if (tick_i) begin
      if (at_end) cnt_q <= '0;
      else        cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  p_restart_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> cnt_q == '0);

  p_hold_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> cnt_q == '0);

  p_cnt_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i |-> cnt_q < period_i);

endmodule

// File: rtl/wsr_stretch.sv
module wsr_stretch #(
  parameter int unsigned RST_TICKS = 200,
  parameter int unsigned PUR_TICKS = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic supply_ok_i,
  input  logic trigger_i,
  output logic active_o
);

  localparam int unsigned MAX_TICKS = (RST_TICKS > PUR_TICKS) ? RST_TICKS : PUR_TICKS;
  localparam int unsigned RCNT_W    = $clog2(MAX_TICKS + 1);

  logic              active_q;
  logic [RCNT_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b1;
      left_q   <= RCNT_W'(PUR_TICKS);
    end else if (!supply_ok_i) begin
      active_q <= 1'b1;
      left_q   <= RCNT_W'(RST_TICKS);
    end else if (trigger_i) begin
      active_q <= 1'b1;
      left_q   <= RCNT_W'(RST_TICKS);
    end else if (active_q && tick_i) begin
      if (left_q <= RCNT_W'(1)) begin
        active_q <= 1'b0;
        left_q   <= '0;
      end else begin
        left_q   <= left_q - RCNT_W'(1);
      end
    end
  end

  assign active_o = active_q;

  p_trigger_asserts_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trigger_i |=> active_q);

  p_supply_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> active_q);

  p_release_on_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_q) |-> $past(tick_i) && $past(supply_ok_i));

endmodule

// File: rtl/wdt_supply_reset.sv
module wdt_supply_reset #(
  parameter int unsigned LONG_TICKS  = 1400,
  parameter int unsigned MID_TICKS   = 600,
  parameter int unsigned SHORT_TICKS = 200,
  parameter int unsigned RST_TICKS   = 200,
  parameter int unsigned PUR_TICKS   = 200,
  parameter bit          ACTIVE_HIGH = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [1:0] sel_i,
  input  logic       cs_i,
  input  logic       supply_ok_i,
  output logic       reset_o
);
  import wsr_pkg::*;

  localparam int unsigned CNT_W = $clog2(LONG_TICKS + 1);

  wd_sel_e          sel;
  logic [1:0]       sel_q;
  logic             sel_chg;
  logic [CNT_W-1:0] period;
  logic             wd_en;
  logic             cs_fall;
  logic             wd_expire;
  logic             rst_active;

  assign sel = wd_sel_e'(sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= WD_OFF;
    else         sel_q <= sel_i;
  end

  assign sel_chg = (sel_i != sel_q);

  always_comb begin
    wd_en = 1'b1;
    unique case (sel)
      WD_LONG:  period = CNT_W'(LONG_TICKS);
      WD_MID:   period = CNT_W'(MID_TICKS);
      WD_SHORT: period = CNT_W'(SHORT_TICKS);
      default: begin
        period = CNT_W'(SHORT_TICKS);
        wd_en  = 1'b0;
      end
    endcase
  end

  wsr_cs_sync #(.SYNC_STAGES(2)) u_cs_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_i      (cs_i),
    .cs_fall_o (cs_fall)
  );

  wsr_wdog #(.CNT_W(CNT_W)) u_wdog (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .enable_i  (wd_en),
    .hold_i    (rst_active),
    .restart_i (cs_fall | sel_chg),
    .period_i  (period),
    .expire_o  (wd_expire)
  );

  wsr_stretch #(.RST_TICKS(RST_TICKS), .PUR_TICKS(PUR_TICKS)) u_stretch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .supply_ok_i (supply_ok_i),
    .trigger_i   (wd_expire),
    .active_o    (rst_active)
  );

  generate
    if (ACTIVE_HIGH) begin : g_pol_high
      assign reset_o = rst_active;
    end else begin : g_pol_low
      assign reset_o = ~rst_active;
    end
  endgenerate

  p_off_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 2'b11) |-> !wd_expire);

  p_no_expire_in_reset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_active |-> !wd_expire);

endmodule

// File: tb/wdt_supply_reset_tb.sv
module wdt_supply_reset_tb;

  localparam int CLK_P = 10;
  localparam int LONG  = 9;
  localparam int MID   = 6;
  localparam int SHORT = 3;
  localparam int RST   = 4;
  localparam int PUR   = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       cs = 1'b1;
  logic       sup = 1'b1;
  logic       reset_lo, reset_hi;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  wdt_supply_reset #(.LONG_TICKS(LONG), .MID_TICKS(MID), .SHORT_TICKS(SHORT),
    .RST_TICKS(RST), .PUR_TICKS(PUR), .ACTIVE_HIGH(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sel_i(sel), .cs_i(cs),
    .supply_ok_i(sup), .reset_o(reset_lo));

  wdt_supply_reset #(.LONG_TICKS(LONG), .MID_TICKS(MID), .SHORT_TICKS(SHORT),
    .RST_TICKS(RST), .PUR_TICKS(PUR), .ACTIVE_HIGH(1'b1)) u_dut_hi (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sel_i(sel), .cs_i(cs),
    .supply_ok_i(sup), .reset_o(reset_hi));

  function automatic int period_of(input int s);
    case (s)
      0:       return LONG;
      1:       return MID;
      default: return SHORT;
    endcase
  endfunction

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input logic exp_act, input string tag);
    checks++;
    if (reset_lo !== ~exp_act) begin
      failures++;
      $display("FAIL %s: low-polarity reset_o=%b expected %b", tag, reset_lo, ~exp_act);
    end
    checks++;
    if (reset_hi !== exp_act) begin
      failures++;
      $display("FAIL R7 %s: high-polarity reset_o=%b expected %b", tag, reset_hi, exp_act);
    end
  endtask

  task automatic kick();
    @(negedge clk) cs = 1'b0;
    idle(4);
    cs = 1'b1;
    idle(4);
  endtask

  task automatic set_sel(input logic [1:0] v);
    @(negedge clk) sel = v;
    idle(2);
  endtask

  task automatic release_pulse(input string tag);
    tick_n(RST - 1);
    chk(1'b1, {tag, " R4 held RST-1"});
    tick_n(1);
    chk(1'b0, {tag, " R4 released"});
  endtask

  initial begin
    idle(2);
    chk(1'b1, "R6 in reset");
    @(negedge clk) rst_n = 1'b1;
    tick_n(PUR - 1);
    chk(1'b1, "R6 PUR-1 ticks");
    tick_n(1);
    chk(1'b0, "R6 released");

    // R1/R2/R3 sweep over every select code and kick position
    for (int s = 0; s < 3; s++) begin
      int p;
      p = period_of(s);
      set_sel(2'(s));
      for (int k = 1; k < p; k++) begin
        tick_n(k);
        kick();
        tick_n(p - 1);
        chk(1'b0, "R2 kick restarts count");
        tick_n(1);
        chk(1'b1, "R1 R3 expiry at period after kick");
        release_pulse("R1");
      end
    end

    // R9: count restarts from zero after release, cs held high (R3)
    set_sel(2'b01);
    tick_n(MID - 1);
    chk(1'b0, "R9 full period needed");
    tick_n(1);
    chk(1'b1, "R3 expiry with cs high");
    release_pulse("R9");

    // R3: cs held low
    @(negedge clk) cs = 1'b0;
    idle(4);
    tick_n(MID - 1);
    chk(1'b0, "R3 cs low before period");
    tick_n(1);
    chk(1'b1, "R3 expiry with cs low");
    release_pulse("R3");
    @(negedge clk) cs = 1'b1;
    idle(4);

    // R3: rising edge does not restart
    set_sel(2'b10);
    kick();
    @(negedge clk) cs = 1'b0;
    idle(4);
    tick_n(SHORT - 1);
    chk(1'b0, "R2 before period");
    @(negedge clk) cs = 1'b1;
    idle(4);
    tick_n(1);
    chk(1'b1, "R3 rising edge gave no restart");
    release_pulse("R3b");

    // R10: select change restarts
    set_sel(2'b00);
    tick_n(5);
    set_sel(2'b10);
    tick_n(SHORT - 1);
    chk(1'b0, "R10 new period from change");
    tick_n(1);
    chk(1'b1, "R10 expiry at new period");
    release_pulse("R10");

    // R11: disabled
    set_sel(2'b11);
    tick_n(3 * LONG);
    chk(1'b0, "R11 disabled never expires");
    set_sel(2'b10);
    tick_n(SHORT - 1);
    chk(1'b0, "R11 re-enabled before period");
    tick_n(1);
    chk(1'b1, "R11 re-enabled expiry");
    release_pulse("R11");

    // R5: supply low
    set_sel(2'b11);
    @(negedge clk) sup = 1'b0;
    @(negedge clk);
    chk(1'b1, "R5 asserted next edge");
    tick_n(10);
    chk(1'b1, "R5 held while low");
    @(negedge clk) sup = 1'b1;
    tick_n(2);
    @(negedge clk) sup = 1'b0;
    @(negedge clk) sup = 1'b1;
    tick_n(RST - 1);
    chk(1'b1, "R5 RST-1 ticks after return");
    tick_n(1);
    chk(1'b0, "R5 released");

    // R8: supply loss during watchdog pulse
    set_sel(2'b10);
    tick_n(SHORT);
    chk(1'b1, "R8 watchdog pulse");
    tick_n(1);
    @(negedge clk) sup = 1'b0;
    idle(2);
    @(negedge clk) sup = 1'b1;
    tick_n(RST - 1);
    chk(1'b1, "R8 release interval restarted");
    tick_n(1);
    chk(1'b0, "R8 released");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run hung, got no completion expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule